// File: doc/BRIEF.md
# Multi-Partition Flash Status Register

This block holds the 16-bit status word of a NOR-style flash controller whose array is split into several partitions. An internal program/erase engine reports which partitions are busy or suspended and which partition the current read targets. The block turns these indications into self-maintained status bits. It also records failure events from the engine and the command decoder as sticky error bits, which software reads back in read-status mode.

Error bits hold their value until a Clear Status command or a reset. Clear Status is a single bus write of code 0x0050, which is accepted at any address. It clears the error bits, and it switches the partition named in that write into read-status mode. The read mode of every other partition is left unchanged.

The ready bit and the partition bit together tell software one of three things: the addressed partition is busy, some other partition is busy, or the whole device is idle. A command-sequence error marks both the program error bit and the erase error bit. Software must therefore clear these bits before it resumes a suspended erase. Otherwise a real erase failure stays hidden behind them.

Top module: `flash_status_reg`

## Requirements
- R1: While reset is held, and after its release, `status_word` reads 0x0080 and every bit of `rd_status_mode` reads 0.
- R2: Bits 15 down to 8 of `status_word` always read 0.
- R3: One clock after the busy vector and the addressed index are presented, {bit 7, bit 0} reads one of three values. It is 2'b00 when the addressed partition is busy. It is 2'b01 when the addressed partition is idle but another partition is busy. It is 2'b10 when no partition is busy.
- R4: One clock after the inputs are presented, bit 6 reads 1 when any partition has an erase suspended, and bit 2 reads 1 when any partition has a program suspended. Each bit returns to 0 when its suspend indications drop, with no command needed.
- R5: A strobe on the matching error input sets the matching bit one clock later: erase error sets bit 5, program error sets bit 4, voltage error sets bit 3 and locked-block abort sets bit 1. The bit then stays set until it is cleared.
- R6: A command-sequence error strobe sets bits 5 and 4 together, one clock later. A later erase error therefore causes no visible change.
- R7: A bus write with data 0x0050 clears bits 5, 4, 3 and 1 one clock later, whatever the partition field of the write. A write with any other data value leaves the error bits unchanged.
- R8: A Clear Status write sets `rd_status_mode[bus_part]` one clock later. All other bits of `rd_status_mode` keep their value, and a write with any other data value changes none of them.
- R9: If an error strobe arrives in the same cycle as a Clear Status write, the bit that the strobe targets ends set, and the other error bits clear.
- R10: Clear Status clears bit 3 and the other error bits even while the voltage error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_busy | input | NUM_PART | Program or erase active, one bit per partition |
| part_prog_susp | input | NUM_PART | Program suspended, one bit per partition |
| part_erase_susp | input | NUM_PART | Erase suspended, one bit per partition |
| rd_part | input | PART_W | Index of the partition addressed by the status read |
| ev_prog_err | input | 1 | Program failure strobe |
| ev_erase_err | input | 1 | Erase failure strobe |
| ev_volt_err | input | 1 | Programming-voltage failure strobe |
| ev_lock_err | input | 1 | Operation aborted on locked block strobe |
| ev_seq_err | input | 1 | Command-sequence error strobe |
| bus_we | input | 1 | Bus write cycle |
| bus_part | input | PART_W | Partition targeted by the bus write |
| bus_data | input | 16 | Command code on the bus write |
| status_word | output | 16 | Status word returned in read-status mode |
| rd_status_mode | output | NUM_PART | Per-partition read-status mode flag |

## Verification
A corrupted error register shows up at the status port as a bit that stays set after a clear, or that drops with no clear. Every such fault becomes visible on the first read after the cycle it happens. A wrong busy or suspend decode shows within one clock of any change in the engine inputs, as a wrong {bit 7, bit 0} pair or a wrong suspend flag. A fault in the command decoder shows up in one of two ways. Either `rd_status_mode` changes for a partition that was not written, or the error bits survive a 0x0050 write. The suspend, sequence-error and hidden-erase-error scenario is run as a directed case, because random stimulus rarely produces it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W = 16;

  typedef struct packed {
    logic erase_err;
    logic prog_err;
    logic volt_err;
    logic lock_err;
  } err_flags_t;

  typedef struct packed {
    logic ready;
    logic erase_susp;
    logic prog_susp;
    logic part_other;
  } live_flags_t;

  localparam err_flags_t  ERR_NONE   = '{erase_err: 1'b0, prog_err: 1'b0, volt_err: 1'b0, lock_err: 1'b0};
  localparam live_flags_t LIVE_RESET = '{ready: 1'b1, erase_susp: 1'b0, prog_susp: 1'b0, part_other: 1'b0};
endpackage

// File: rtl/fsr_live_status.sv
module fsr_live_status
  import fsr_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PART-1:0] part_busy,
  input  logic [NUM_PART-1:0] part_prog_susp,
  input  logic [NUM_PART-1:0] part_erase_susp,
  input  logic [PART_W-1:0]   rd_part,
  output live_flags_t         live_q
);
  logic        sel_busy;
  logic        any_busy;
  live_flags_t live_d;

  always_comb begin
    sel_busy = 1'b0;
    for (int i = 0; i < NUM_PART; i++) begin
      if (rd_part == PART_W'(i)) sel_busy = part_busy[i];
    end
  end

  always_comb begin
    any_busy          = |part_busy;
    live_d.ready      = ~any_busy;
    live_d.part_other = any_busy & ~sel_busy;
    live_d.erase_susp = |part_erase_susp;
    live_d.prog_susp  = |part_prog_susp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= LIVE_RESET;
    else        live_q <= live_d;
  end

  // R3: idle and "other partition busy" are mutually exclusive
  assert_ready_part_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_q.ready && live_q.part_other));

  // R3: ready follows an idle engine
  assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (part_busy == '0) |=> live_q.ready);

  // R4: suspend flags drop without any command once indications clear
  assert_susp_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (part_prog_susp == '0 && part_erase_susp == '0) |=> (!live_q.prog_susp && !live_q.erase_susp));
endmodule

// File: rtl/fsr_err_sticky.sv
module fsr_err_sticky
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ev_prog_err,
  input  logic       ev_erase_err,
  input  logic       ev_volt_err,
  input  logic       ev_lock_err,
  input  logic       ev_seq_err,
  output err_flags_t err_q
);
  err_flags_t set_v;
  err_flags_t err_d;
  logic       any_ev;

  always_comb begin
    set_v.erase_err = ev_erase_err | ev_seq_err;
    set_v.prog_err  = ev_prog_err  | ev_seq_err;
    set_v.volt_err  = ev_volt_err;
    set_v.lock_err  = ev_lock_err;
    any_ev          = ev_prog_err | ev_erase_err | ev_volt_err | ev_lock_err | ev_seq_err;
  end

  // a new event wins over a clear in the same cycle
  always_comb begin
    if (clr) err_d = set_v;
    else     err_d = err_flags_t'(err_q | set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= ERR_NONE;
    else        err_q <= err_d;
  end

  // R5: an error bit stays set until a clear
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R6: sequence error marks both program and erase error
  assert_seq_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> (err_q.erase_err && err_q.prog_err));

  // R7, R10: a clear with no event empties every error bit, voltage included
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_ev) |=> (err_q == ERR_NONE));

  // R9: an event beside a clear survives it
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev_lock_err) |=> err_q.lock_err);
endmodule

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode #(
  parameter int          NUM_PART = 4,
  parameter int          PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
  parameter int          CMD_W    = 16,
  parameter logic [15:0] CLR_CODE = 16'h0050
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [PART_W-1:0]   bus_part,
  input  logic [CMD_W-1:0]    bus_data,
  output logic                clr_hit,
  output logic [NUM_PART-1:0] mode_q
);
  logic [NUM_PART-1:0] mode_d;

  assign clr_hit = bus_we && (bus_data == CMD_W'(CLR_CODE));

  for (genvar g = 0; g < NUM_PART; g++) begin : g_mode
    always_comb begin
      mode_d[g] = mode_q[g] | (clr_hit && (bus_part == PART_W'(g)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[g] <= 1'b0;
      else        mode_q[g] <= mode_d[g];
    end
  end

  // R8: at most one partition enters read-status mode per write
  assert_one_mode_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(mode_q & ~$past(mode_q)));

  // R8: mode flags change only after a clear write
  assert_mode_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> $stable(mode_q));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
#(
  parameter int          NUM_PART = 4,
  parameter int          PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
  parameter logic [15:0] CLR_CODE = 16'h0050
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PART-1:0] part_busy,
  input  logic [NUM_PART-1:0] part_prog_susp,
  input  logic [NUM_PART-1:0] part_erase_susp,
  input  logic [PART_W-1:0]   rd_part,
  input  logic                ev_prog_err,
  input  logic                ev_erase_err,
  input  logic                ev_volt_err,
  input  logic                ev_lock_err,
  input  logic                ev_seq_err,
  input  logic                bus_we,
  input  logic [PART_W-1:0]   bus_part,
  input  logic [15:0]         bus_data,
  output logic [15:0]         status_word,
  output logic [NUM_PART-1:0] rd_status_mode
);
  live_flags_t live_q;
  err_flags_t  err_q;
  logic        clr_hit;

  fsr_live_status #(.NUM_PART(NUM_PART), .PART_W(PART_W)) u_live (
    .clk            (clk),
    .rst_n          (rst_n),
    .part_busy      (part_busy),
    .part_prog_susp (part_prog_susp),
    .part_erase_susp(part_erase_susp),
    .rd_part        (rd_part),
    .live_q         (live_q)
  );

  fsr_cmd_decode #(.NUM_PART(NUM_PART), .PART_W(PART_W), .CMD_W(16), .CLR_CODE(CLR_CODE)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_we  (bus_we),
    .bus_part(bus_part),
    .bus_data(bus_data),
    .clr_hit (clr_hit),
    .mode_q  (rd_status_mode)
  );

  // the voltage event is not an input to the clear path
  fsr_err_sticky u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr_hit),
    .ev_prog_err (ev_prog_err),
    .ev_erase_err(ev_erase_err),
    .ev_volt_err (ev_volt_err),
    .ev_lock_err (ev_lock_err),
    .ev_seq_err  (ev_seq_err),
    .err_q       (err_q)
  );

  always_comb begin
    status_word     = '0;
    status_word[7]  = live_q.ready;
    status_word[6]  = live_q.erase_susp;
    status_word[5]  = err_q.erase_err;
    status_word[4]  = err_q.prog_err;
    status_word[3]  = err_q.volt_err;
    status_word[2]  = live_q.prog_susp;
    status_word[1]  = err_q.lock_err;
    status_word[0]  = live_q.part_other;
  end

  // R3: encoding 2'b11 for {ready, partition} never appears
  assert_no_code11_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[7] && status_word[0]));
endmodule

// File: tb/flash_status_reg_tb.sv
module flash_status_reg_tb;
  localparam int NP = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] part_busy, part_prog_susp, part_erase_susp;
  logic [PW-1:0] rd_part, bus_part;
  logic          ev_prog_err, ev_erase_err, ev_volt_err, ev_lock_err, ev_seq_err, bus_we;
  logic [15:0]   bus_data;
  logic [15:0]   status_word;
  logic [NP-1:0] rd_status_mode;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0]    m_err;
  logic [NP-1:0] m_mode;

  always #4 clk = ~clk;

  flash_status_reg #(.NUM_PART(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .part_busy(part_busy), .part_prog_susp(part_prog_susp),
    .part_erase_susp(part_erase_susp), .rd_part(rd_part), .ev_prog_err(ev_prog_err),
    .ev_erase_err(ev_erase_err), .ev_volt_err(ev_volt_err), .ev_lock_err(ev_lock_err),
    .ev_seq_err(ev_seq_err), .bus_we(bus_we), .bus_part(bus_part), .bus_data(bus_data),
    .status_word(status_word), .rd_status_mode(rd_status_mode)
  );

  function automatic logic [15:0] exp_word(input logic [NP-1:0] b, input logic [NP-1:0] ps,
                                           input logic [NP-1:0] es, input logic [PW-1:0] a,
                                           input logic [3:0] e);
    logic any;
    any = |b;
    exp_word = {8'h00, ~any, |es, e[3], e[2], e[1], |ps, e[0], any & ~b[a]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ev = {prog, erase, volt, lock, seq}; all inputs applied at a falling edge
  task automatic step(input string tag, input logic [NP-1:0] b, input logic [NP-1:0] ps,
                      input logic [NP-1:0] es, input logic [PW-1:0] a, input logic [4:0] ev,
                      input logic we, input logic [PW-1:0] bp, input logic [15:0] d);
    logic       clr;
    logic [3:0] setv;
    part_busy = b; part_prog_susp = ps; part_erase_susp = es; rd_part = a;
    {ev_prog_err, ev_erase_err, ev_volt_err, ev_lock_err, ev_seq_err} = ev;
    bus_we = we; bus_part = bp; bus_data = d;
    clr  = we && (d == 16'h0050);
    setv = {ev[3] | ev[0], ev[4] | ev[0], ev[2], ev[1]};
    m_err = clr ? setv : (m_err | setv);
    if (clr) m_mode[bp] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(tag, status_word, exp_word(b, ps, es, a, m_err));
    chk({tag, " mode"}, {12'h0, rd_status_mode}, {12'h0, m_mode});
  endtask

  task automatic idle(input string tag);
    step(tag, '0, '0, '0, '0, 5'b0, 1'b0, '0, 16'h0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    part_busy = '0; part_prog_susp = '0; part_erase_susp = '0; rd_part = '0;
    {ev_prog_err, ev_erase_err, ev_volt_err, ev_lock_err, ev_seq_err} = '0;
    bus_we = 1'b0; bus_part = '0; bus_data = '0;
    m_err = '0; m_mode = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", status_word, 16'h0080);
    chk("R1 reset mode", {12'h0, rd_status_mode}, 16'h0);
    rst_n = 1'b1;
    idle("R1 after release");
    chk("R2 upper zero", {8'h0, status_word[15:8]}, 16'h0);

    step("R3 addressed busy", 4'b0100, '0, '0, 2'd2, 5'b0, 1'b0, '0, 16'h0);
    chk("R3 code 00", {14'h0, status_word[7], status_word[0]}, 16'h0000);
    step("R3 other busy", 4'b0100, '0, '0, 2'd1, 5'b0, 1'b0, '0, 16'h0);
    chk("R3 code 01", {14'h0, status_word[7], status_word[0]}, 16'h0001);
    idle("R3 idle");
    chk("R3 code 10", {14'h0, status_word[7], status_word[0]}, 16'h0002);

    step("R4 suspends", '0, 4'b0010, 4'b1000, '0, 5'b0, 1'b0, '0, 16'h0);
    chk("R4 bits", status_word, 16'h00C4);
    idle("R4 self clear");
    chk("R4 cleared", status_word, 16'h0080);

    step("R5 erase", '0, '0, '0, '0, 5'b01000, 1'b0, '0, 16'h0);
    step("R5 prog", '0, '0, '0, '0, 5'b10000, 1'b0, '0, 16'h0);
    step("R5 volt", '0, '0, '0, '0, 5'b00100, 1'b0, '0, 16'h0);
    step("R5 lock", '0, '0, '0, '0, 5'b00010, 1'b0, '0, 16'h0);
    idle("R5 sticky");
    chk("R5 all set", status_word, 16'h00BA);
    step("R7 wrong code", '0, '0, '0, '0, 5'b0, 1'b1, 2'd3, 16'h0051);
    chk("R7 ignored", status_word, 16'h00BA);
    chk("R8 ignored", {12'h0, rd_status_mode}, 16'h0);
    step("R10 clear with volt set", '0, '0, '0, '0, 5'b0, 1'b1, 2'd3, 16'h0050);
    chk("R10 cleared", status_word, 16'h0080);
    chk("R8 only p3", {12'h0, rd_status_mode}, 16'h0008);

    step("R9 lock beside clear", '0, '0, '0, '0, 5'b00110, 1'b1, 2'd1, 16'h0050);
    chk("R9 event wins", status_word, 16'h008A);
    step("R7 clear", '0, '0, '0, '0, 5'b0, 1'b1, 2'd1, 16'h0050);
    chk("R7 empty", status_word, 16'h0080);

    // R6: suspend, sequence error, later erase error hidden; clear before resume exposes it
    step("R6 suspended", 4'b0000, '0, 4'b0001, 2'd0, 5'b0, 1'b0, '0, 16'h0);
    step("R6 seq err", 4'b0000, '0, 4'b0001, 2'd0, 5'b00001, 1'b0, '0, 16'h0);
    chk("R6 both set", status_word, 16'h00F0);
    step("R6 resume", 4'b0001, '0, '0, 2'd0, 5'b0, 1'b0, '0, 16'h0);
    step("R6 hidden erase err", 4'b0001, '0, '0, 2'd0, 5'b01000, 1'b0, '0, 16'h0);
    chk("R6 masked", status_word, 16'h0030);
    step("R6 clear", '0, '0, '0, '0, 5'b0, 1'b1, 2'd0, 16'h0050);
    step("R6 resume clean", 4'b0001, '0, '0, 2'd0, 5'b0, 1'b0, '0, 16'h0);
    step("R6 exposed erase err", 4'b0001, '0, '0, 2'd0, 5'b01000, 1'b0, '0, 16'h0);
    chk("R6 erase only", status_word, 16'h0020);

    for (int k = 0; k < 400; k++) begin
      logic [4:0] ev;
      logic       we;
      ev = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'b0;
      we = ($urandom_range(0, 4) == 0);
      step("R3 R4 R5 R7 R8 random", 4'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
           ev, we, 2'($urandom), ($urandom_range(0, 1) == 0) ? 16'h0050 : 16'($urandom));
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset word", status_word, 16'h0080);
    chk("R1 re-reset mode", {12'h0, rd_status_mode}, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule